// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received Ethernet-style frames from a MAC byte stream into system memory. Software builds a ring of four-word descriptors, each naming a buffer and its size. The engine walks the ring and fetches one descriptor per frame. It writes the frame bytes into that buffer, starting a programmable number of bytes in. Once the frame has ended, it writes a header word at the buffer start that holds the stored length and a truncation flag. It then moves its current-descriptor pointer on, so software can see that a new frame has arrived.

Software gives descriptors to the engine by moving a last-descriptor pointer. When the current pointer reaches that pointer, no descriptor is available. The engine then either holds the input stream back or, with overflow-continue set, accepts and discards whole frames while it counts them. Clearing the enable bit stops the engine at the next frame boundary, never in the middle of a frame.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the engine is disabled: status state code 0, current pointer 0, drop count 0, `in_ready` low and no memory access.
- R2: Setting the enable bit (control bit 0) loads the current pointer from the base register. Each stored frame consumes one descriptor, and the pointer then advances by 16 bytes in the same cycle as its header write.
- R3: A descriptor is four 32-bit words at pointer +0, +4, +8 and +12. Word 0 bit 28 marks the last entry of the ring. Word 1 bits [14:0] give the buffer size in bytes. Word 2 gives the word-aligned buffer address. After a frame in a marked descriptor, the pointer returns to the base address.
- R4: A descriptor is fetched only while the current pointer differs from the last-descriptor pointer. When the two are equal, the engine has no descriptor and makes no memory access.
- R5: Frame byte i is written to buffer address + offset + i, where the offset is control bits [15:8]. Bytes are little-endian within 32-bit words and each is written with a single byte strobe.
- R6: After the data, the engine writes the word at the buffer address once. Bits [15:0] hold the stored byte count, bit 16 is the truncation flag and the remaining bits are zero.
- R7: Buffer capacity is the size minus the offset, or 0 if the size does not exceed the offset. Bytes beyond the capacity are accepted but not written, and they set the truncation flag.
- R8: With overflow-continue (control bit 1) clear and no descriptor available, `in_ready` stays low and the status state code is 2.
- R9: With overflow-continue set and no descriptor available, a whole incoming frame is accepted and discarded. The drop count (status bits [31:16]) goes up by one, the pointer does not move and memory is left untouched.
- R10: Clearing the enable bit during a frame lets that frame complete with its header. The state code becomes 0 at the next boundary, and `in_ready` then stays low.
- R11: Register map by word index: 0 control, 1 base, 2 last-descriptor pointer, 3 current pointer (read-only), 4 status (read-only; [1:0] state code with 0 disabled, 1 busy, 2 waiting; [31:16] drop count).
- R12: A stream byte transfers in a cycle where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source holds `in_data` and `in_last` stable, and `in_last` marks the final byte of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Engine accepts a byte |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of the frame |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte strobes for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The bench places frames at two different offsets and checks the untouched bytes just below the data. A design that ignored the offset or wrote whole words would overwrite them. It sends a frame longer than the buffer and checks the header length and flag and the word just past the capacity, which a design without the clamp would overwrite. It drives the ring to exhaustion in both overflow modes, where a faulty design would either accept data into no buffer or move the pointer on a dropped frame. It also checks a wrap through the descriptor marked as last and a disable in the middle of a frame. A design that ignored the wrap would walk past the ring, and one that stopped at once would leave the frame without its header.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int DW         = 32;
  localparam int DESC_BYTES = 16;

  typedef enum logic [3:0] {
    S_OFF, S_CHECK, S_RD0, S_RD1, S_RD2, S_RD3, S_RECV, S_HDR, S_DROP
  } eng_state_t;

  localparam logic [1:0] CODE_OFF  = 2'd0;
  localparam logic [1:0] CODE_BUSY = 2'd1;
  localparam logic [1:0] CODE_WAIT = 2'd2;
endpackage

// File: rtl/rxd_regs.sv
module rxd_regs
  import rxd_pkg::*;
#(
  parameter int OFS_W  = 8,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              en,
  output logic              ovf,
  output logic [OFS_W-1:0]  ofs,
  output logic [DW-1:0]     base,
  output logic [DW-1:0]     last,
  input  logic [DW-1:0]     cur,
  input  logic [1:0]        st_code,
  input  logic [DROP_W-1:0] drop_cnt
);
  localparam int OFS_LSB  = 8;
  localparam int DROP_LSB = 16;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      ovf  <= 1'b0;
      ofs  <= '0;
      base <= '0;
      last <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: begin
          en  <= reg_wdata[0];
          ovf <= reg_wdata[1];
          ofs <= reg_wdata[OFS_LSB +: OFS_W];
        end
        3'd1: base <= reg_wdata;
        3'd2: last <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: begin
        reg_rdata[0]                = en;
        reg_rdata[1]                = ovf;
        reg_rdata[OFS_LSB +: OFS_W] = ofs;
      end
      3'd1: reg_rdata = base;
      3'd2: reg_rdata = last;
      3'd3: reg_rdata = cur;
      3'd4: begin
        reg_rdata[1:0]                 = st_code;
        reg_rdata[DROP_LSB +: DROP_W]  = drop_cnt;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rxd_ring.sv
module rxd_ring
  import rxd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic          wrap,
  input  logic [DW-1:0] base,
  output logic [DW-1:0] cur
);
  localparam logic [DW-1:0] STEP = DW'(DESC_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n)       cur <= '0;
    else if (load)    cur <= base;
    else if (advance) cur <= wrap ? base : cur + STEP;
  end
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
#(
  parameter int OFS_W   = 8,
  parameter int BSZ_W   = 15,
  parameter int LEN_W   = 16,
  parameter int EOT_BIT = 28,
  parameter int DROP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ovf,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DW-1:0]     cur,
  input  logic [DW-1:0]     last,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              mem_en,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [3:0]        mem_be,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              load,
  output logic              advance,
  output logic              wrap,
  output logic [DROP_W-1:0] drop_cnt,
  output logic [1:0]        st_code
);
  localparam int TRUNC_BIT = LEN_W;

  eng_state_t st, st_nx;
  logic             eot_q, trunc_q, started_q;
  logic [LEN_W-1:0] cap_q, cnt_q;
  logic [DW-1:0]    bufa_q, wptr_q;
  logic [LEN_W-1:0] bsz_x, ofs_x;
  logic             avail, acc, room;
  logic             unused_low;

  assign avail      = (cur != last);
  assign acc        = in_valid && in_ready;
  assign room       = (cnt_q < cap_q);
  assign bsz_x      = LEN_W'(mem_rdata[BSZ_W-1:0]);
  assign ofs_x      = LEN_W'(ofs);
  assign wrap       = eot_q;
  assign unused_low = ^bufa_q[1:0];

  always_comb begin
    st_nx     = st;
    in_ready  = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = '0;
    mem_wdata = '0;
    load      = 1'b0;
    advance   = 1'b0;
    case (st)
      S_OFF: if (en) begin
        load  = 1'b1;
        st_nx = S_CHECK;
      end
      S_CHECK: begin
        if (!en)                 st_nx = S_OFF;
        else if (avail)          st_nx = S_RD0;
        else if (ovf && in_valid) st_nx = S_DROP;
      end
      S_RD0: begin
        mem_en   = 1'b1;
        mem_addr = cur;
        st_nx    = S_RD1;
      end
      S_RD1: begin
        mem_en   = 1'b1;
        mem_addr = cur + DW'(4);
        st_nx    = S_RD2;
      end
      S_RD2: begin
        mem_en   = 1'b1;
        mem_addr = cur + DW'(8);
        st_nx    = S_RD3;
      end
      S_RD3: st_nx = S_RECV;
      S_RECV: begin
        in_ready = en || started_q;
        if (!en && !started_q) begin
          st_nx = S_OFF;
        end else if (acc) begin
          if (room) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {wptr_q[DW-1:2], 2'b00};
            mem_be    = 4'b0001 << wptr_q[1:0];
            mem_wdata = {4{in_data}};
          end
          if (in_last) st_nx = S_HDR;
        end
      end
      S_HDR: begin
        mem_en                 = 1'b1;
        mem_we                 = 1'b1;
        mem_addr               = {bufa_q[DW-1:2], 2'b00};
        mem_be                 = 4'b1111;
        mem_wdata[LEN_W-1:0]   = cnt_q;
        mem_wdata[TRUNC_BIT]   = trunc_q;
        advance                = 1'b1;
        st_nx                  = S_CHECK;
      end
      S_DROP: begin
        in_ready = 1'b1;
        if (acc && in_last) st_nx = S_CHECK;
      end
      default: st_nx = S_OFF;
    endcase
  end

  always_comb begin
    case (st)
      S_OFF:   st_code = CODE_OFF;
      S_CHECK: st_code = avail ? CODE_BUSY : CODE_WAIT;
      default: st_code = CODE_BUSY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_OFF;
      eot_q     <= 1'b0;
      trunc_q   <= 1'b0;
      started_q <= 1'b0;
      cap_q     <= '0;
      cnt_q     <= '0;
      bufa_q    <= '0;
      wptr_q    <= '0;
      drop_cnt  <= '0;
    end else begin
      st <= st_nx;
      case (st)
        S_RD1: eot_q <= mem_rdata[EOT_BIT];
        S_RD2: cap_q <= (bsz_x > ofs_x) ? (bsz_x - ofs_x) : '0;
        S_RD3: begin
          bufa_q    <= mem_rdata;
          wptr_q    <= mem_rdata + DW'(ofs);
          cnt_q     <= '0;
          trunc_q   <= 1'b0;
          started_q <= 1'b0;
        end
        S_RECV: if (acc) begin
          started_q <= 1'b1;
          if (room) begin
            cnt_q  <= cnt_q + 1'b1;
            wptr_q <= wptr_q + 1'b1;
          end else begin
            trunc_q <= 1'b1;
          end
        end
        S_DROP: if (acc && in_last) drop_cnt <= drop_cnt + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rxd_pkg::*;
#(
  parameter int OFS_W   = 8,
  parameter int BSZ_W   = 15,
  parameter int LEN_W   = 16,
  parameter int EOT_BIT = 28,
  parameter int DROP_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        mem_en,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  logic              en_w, ovf_w, load_w, adv_w, wrap_w;
  logic [OFS_W-1:0]  ofs_w;
  logic [DW-1:0]     base_w, last_w, cur_w;
  logic [1:0]        st_code_w;
  logic [DROP_W-1:0] drop_w;

  rxd_regs #(.OFS_W(OFS_W), .DROP_W(DROP_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .en(en_w), .ovf(ovf_w),
    .ofs(ofs_w), .base(base_w), .last(last_w), .cur(cur_w),
    .st_code(st_code_w), .drop_cnt(drop_w)
  );

  rxd_ring i_ring (
    .clk(clk), .rst_n(rst_n), .load(load_w), .advance(adv_w),
    .wrap(wrap_w), .base(base_w), .cur(cur_w)
  );

  rxd_engine #(
    .OFS_W(OFS_W), .BSZ_W(BSZ_W), .LEN_W(LEN_W),
    .EOT_BIT(EOT_BIT), .DROP_W(DROP_W)
  ) i_eng (
    .clk(clk), .rst_n(rst_n), .en(en_w), .ovf(ovf_w), .ofs(ofs_w),
    .cur(cur_w), .last(last_w), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .load(load_w), .advance(adv_w), .wrap(wrap_w),
    .drop_cnt(drop_w), .st_code(st_code_w)
  );
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker
  import rxd_pkg::*;
#(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              mem_en,
  input logic [DW-1:0]     mem_addr,
  input logic [DW-1:0]     cur,
  input logic [DW-1:0]     base,
  input logic              ovf,
  input logic [DROP_W-1:0] drop_cnt,
  input logic [1:0]        st_code
);
  AST_DIS_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == CODE_OFF) |-> !in_ready); // R10

  AST_STALL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == CODE_WAIT && !ovf) |-> !in_ready); // R8

  AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[1:0] == 2'b00)); // R5

  AST_MEM_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (st_code == CODE_BUSY)); // R4

  AST_CUR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != $past(cur)) |-> (cur == $past(cur) + DW'(DESC_BYTES) || cur == $past(base))); // R3

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + DROP_W'(1) && $past(ovf))); // R9
endmodule

bind rx_ring_dma rxd_checker #(.DROP_W(DROP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_en(mem_en),
  .mem_addr(mem_addr), .cur(cur_w), .base(base_w), .ovf(ovf_w),
  .drop_cnt(drop_w), .st_code(st_code_w)
);

// File: tb/test_rx_ring_dma.sv
module test_rx_ring_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rx_ring_dma i_rx_ring_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model with a backdoor write path for setup
  logic [31:0] mem [0:1023];
  logic [31:0] rdq = '0;
  logic        bd_we = 1'b0;
  logic [9:0]  bd_idx = '0;
  logic [31:0] bd_val = '0;
  assign mem_rdata = rdq;

  always @(posedge clk) begin
    if (bd_we) mem[bd_idx] <= bd_val;
    if (mem_en && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_en && !mem_we) rdq <= mem[mem_addr[11:2]];
  end

  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam logic [31:0] EN = 32'h1, OVF = 32'h2;

  function automatic logic [7:0] mb(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bd(input int idx, input logic [31:0] v);
    @(negedge clk); bd_we = 1'b1; bd_idx = idx[9:0]; bd_val = v;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] v);
    @(negedge clk); reg_addr = a[2:0]; #1; v = reg_rdata;
  endtask

  task automatic wait_reg(input int a, input logic [31:0] mask, input logic [31:0] exp, input string req);
    logic [31:0] v;
    int n = 0;
    reg_rd(a, v);
    while ((v & mask) != exp && n < 500) begin reg_rd(a, v); n++; end
    check((v & mask) == exp, req, v & mask, exp);
  endtask

  task automatic send_seq(input int first, input int count, input logic [7:0] seed, input bit fin);
    for (int i = first; i < first + count; i++) begin
      int n = 0;
      @(negedge clk);
      in_valid = 1'b1; in_data = seed + 8'(i); in_last = fin && (i == first + count - 1);
      #1;
      while (!in_ready && n < 1000) begin @(negedge clk); #1; n++; end
      if (n >= 1000) check(1'b0, "R12 handshake timeout", 32'(n), 0);
      @(posedge clk);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    reg_rd(4, v); check(v == 0, "R1 status", v, 0);
    reg_rd(3, v); check(v == 0, "R1 cur", v, 0);
    check(!in_ready, "R1 in_ready", 32'(in_ready), 0);
    check(!mem_en, "R1 mem_en", 32'(mem_en), 0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    reg_wr(1, 32'h100); reg_wr(2, 32'h130); reg_wr(0, EN | (32'd4 << 8));
    reg_rd(0, v); check(v == 32'h401, "R11 ctrl readback", v, 32'h401);
    send_seq(0, 10, 8'h10, 1'b1);
    wait_reg(3, 32'hFFFF_FFFF, 32'h110, "R2 cur advance");
    check(mem[32'h400 >> 2] == 10, "R6 header len", mem[32'h400 >> 2], 10);
    for (int i = 0; i < 10; i++)
      check(mb(32'h404 + i) == 8'(8'h10 + i), "R5 data byte", 32'(mb(32'h404 + i)), 32'(8'h10 + i));
  endtask

  task automatic t_offset;
    reg_wr(0, EN | (32'd6 << 8));
    send_seq(0, 5, 8'h40, 1'b1);
    wait_reg(3, 32'hFFFF_FFFF, 32'h120, "R2 cur second");
    check(mem[32'h500 >> 2] == 5, "R6 header len offset", mem[32'h500 >> 2], 5);
    check(mem[32'h504 >> 2] == 32'h4140_BEEF, "R5 offset lanes", mem[32'h504 >> 2], 32'h4140_BEEF);
    check(mem[32'h508 >> 2][23:0] == 24'h44_4342, "R5 next word", mem[32'h508 >> 2], 32'h0044_4342);
  endtask

  task automatic t_trunc;
    send_seq(0, 70, 8'h80, 1'b1);
    wait_reg(3, 32'hFFFF_FFFF, 32'h130, "R2 cur third");
    check(mem[32'h600 >> 2] == 32'h0001_003A, "R7 header trunc", mem[32'h600 >> 2], 32'h0001_003A);
    check(mb(32'h63F) == 8'(8'h80 + 57), "R7 last stored", 32'(mb(32'h63F)), 32'(8'h80 + 57));
    check(mem[32'h640 >> 2] == SENT, "R7 beyond capacity", mem[32'h640 >> 2], SENT);
  endtask

  task automatic t_stall_wrap;
    logic [31:0] v;
    wait_reg(4, 32'h3, 32'h2, "R8 waiting code");
    @(negedge clk); in_valid = 1'b1; in_data = 8'hC0;
    repeat (5) @(negedge clk);
    #1; check(!in_ready, "R8 stalled", 32'(in_ready), 0);
    check(!mem_en, "R4 no access", 32'(mem_en), 0);
    reg_rd(3, v); check(v == 32'h130, "R4 cur held", v, 32'h130);
    reg_wr(2, 32'h110);
    send_seq(0, 4, 8'hC0, 1'b1);
    wait_reg(3, 32'hFFFF_FFFF, 32'h100, "R3 wrap to base");
    check(mem[32'h700 >> 2] == 4, "R3 header in marked desc", mem[32'h700 >> 2], 4);
    send_seq(0, 3, 8'hD0, 1'b1);
    wait_reg(3, 32'hFFFF_FFFF, 32'h110, "R3 after wrap");
    check(mem[32'h400 >> 2] == 3, "R6 header reuse", mem[32'h400 >> 2], 3);
  endtask

  task automatic t_drop;
    logic [31:0] v;
    reg_wr(0, EN | OVF | (32'd6 << 8));
    send_seq(0, 3, 8'h20, 1'b1);
    wait_reg(4, 32'hFFFF_0000, 32'h0001_0000, "R9 drop one");
    reg_rd(3, v); check(v == 32'h110, "R9 cur unchanged", v, 32'h110);
    check(mem[32'h500 >> 2] == 5, "R9 memory untouched", mem[32'h500 >> 2], 5);
    send_seq(0, 2, 8'h30, 1'b1);
    wait_reg(4, 32'hFFFF_0000, 32'h0002_0000, "R9 drop two");
  endtask

  task automatic t_disable;
    logic [31:0] v;
    reg_wr(0, EN | (32'd6 << 8));
    reg_wr(2, 32'h130);
    send_seq(0, 3, 8'hE0, 1'b0);
    reg_wr(0, 32'd6 << 8);
    reg_rd(4, v); check(v[1:0] == 2'd1, "R10 busy during frame", 32'(v[1:0]), 1);
    send_seq(3, 5, 8'hE0, 1'b1);
    wait_reg(4, 32'h3, 32'h0, "R10 disabled at boundary");
    reg_rd(3, v); check(v == 32'h120, "R10 cur after frame", v, 32'h120);
    check(mem[32'h500 >> 2] == 8, "R10 header written", mem[32'h500 >> 2], 8);
    @(negedge clk); in_valid = 1'b1; #1;
    check(!in_ready, "R10 ready low", 32'(in_ready), 0);
    @(negedge clk); in_valid = 1'b0;
    reg_wr(0, EN | (32'd6 << 8));
    wait_reg(3, 32'hFFFF_FFFF, 32'h100, "R2 reload base");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    for (int i = 256; i < 512; i++) bd(i, SENT);
    for (int d = 0; d < 4; d++) begin
      bd((32'h100 >> 2) + 4*d,     (d == 3) ? (32'h1 << 28) : 32'h0);
      bd((32'h100 >> 2) + 4*d + 1, 32'd64);
      bd((32'h100 >> 2) + 4*d + 2, 32'h400 + 32'h100 * d);
      bd((32'h100 >> 2) + 4*d + 3, 32'h0);
    end
    t_basic();
    t_offset();
    t_trunc();
    t_stall_wrap();
    t_drop();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=expired exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule